// File: doc/BRIEF.md
# Interrupt and Stack Sequencer

This block is the part of an 8-bit processor core that owns the program counter, the stack pointer and the status byte while control changes hands. A NMI or IRQ request, a reset strobe, or a decoded stack command from the instruction decoder starts a short run of single-byte bus cycles. These cycles push or pull the return address and the status byte on a fixed stack page. The block then loads a new program counter, either from a little-endian vector or from the pulled bytes.

Requests are only considered while the sequencer is idle. Interrupts are considered only when the core marks an instruction boundary. The reset strobe can cut into any running sequence. The block covers the stack parts of break, push status, pull status, return from interrupt, subroutine call and subroutine return. Fetch, the arithmetic unit and operand addressing are left to the rest of the core, which can also overwrite the program counter while the sequencer is idle.

Top module: `irq_stack_seq`

## Requirements
- R1: A falling edge on nmi_ni is latched as pending, and the edge may come in the same cycle as the boundary strobe. A pending NMI is taken at a boundary ahead of IRQ and ahead of any command. Taking it clears the pending state, so a line that is held low is not taken a second time.
- R2: While irq_ni is low, IRQ is taken at an idle boundary only if status bit 2 (interrupt disable) is 0. Otherwise the request has no effect.
- R3: The stack is page 0x01. A push writes at 0x0100+S and then decrements S. A pull increments S and then reads at 0x0100+S. S wraps modulo 256.
- R4: Interrupt entry writes PC high, then PC low, then status with bit 4 cleared and bit 5 set. It then sets status bit 2 and reads the vector low byte at V and the high byte at V+1. V is 0xFFFA for NMI and 0xFFFE for IRQ.
- R5: Command 0 (break) pushes PC+1 in the same order. It pushes status with bits 4 and 5 set, sets bit 2 and loads PC through 0xFFFE.
- R6: Command 1 (push status) writes the status byte with bits 4 and 5 set and leaves the status register unchanged.
- R7: Command 2 (pull status) pulls one byte into status with bit 5 forced to 1.
- R8: Command 3 (return from interrupt) pulls status as in R7, then the PC low byte, then the PC high byte.
- R9: Command 4 (call) writes PC-1 high and then low, and loads PC from jsr_target_i.
- R10: Command 5 (return) pulls the PC low byte and then the high byte, and loads the pulled value plus one.
- R11: rst_ni leaves PC=0, S=0xFF, status=0x20 and the block idle. The reset strobe sets S=0xFF and status=0x20 at once, aborts any running sequence and loads PC from 0xFFFC/0xFFFD.
- R12: busy_o is high in every bus cycle of a sequence and low once the sequence has completed. While busy, commands and interrupts are ignored. While idle, mem_we_o is 0. Command codes 6 and 7 are ignored.
- R13: pc_set_i loads pc_new_i into PC while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reset_req_i | input | 1 | Processor reset strobe |
| boundary_i | input | 1 | Instruction boundary strobe |
| nmi_ni | input | 1 | NMI request, falling-edge sensitive |
| irq_ni | input | 1 | IRQ request, low level |
| cmd_valid_i | input | 1 | Stack command strobe |
| cmd_i | input | 3 | Stack command code |
| jsr_target_i | input | 16 | Call target address |
| pc_set_i | input | 1 | Overwrite PC while idle |
| pc_new_i | input | 16 | Value for pc_set_i |
| mem_addr_o | output | 16 | Bus address |
| mem_wdata_o | output | 8 | Bus write data |
| mem_we_o | output | 1 | Bus write enable |
| mem_rdata_i | input | 8 | Bus read data, valid in the cycle of the address |
| pc_o | output | 16 | Program counter |
| sp_o | output | 8 | Stack pointer |
| status_o | output | 8 | Status byte |
| busy_o | output | 1 | Sequence in progress |

## Verification
The stack-pointer assertions assume that the memory answers in the cycle of the address. They also assume that every bus cycle on page 0x01 belongs to the stack, so the vectors must sit outside that page. They further assume that reset_req_i is the only request that arrives while busy_o is high, apart from a deliberately ignored command. The stimulus raises each start request for a single idle cycle and keeps irq_ni and nmi_ni constant while a sequence runs. It then checks the reserved-bit rule against preloaded stack bytes, including the pull at S=0xFF that wraps to 0x0100.

// File: rtl/irq_stack_pkg.sv
`timescale 1ns/1ps
package irq_stack_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PUSH_HI, ST_PUSH_LO, ST_PUSH_P,
    ST_VEC_LO, ST_VEC_HI, ST_PULL_P, ST_PULL_LO, ST_PULL_HI
  } seq_state_e;

  typedef enum logic [2:0] {
    OP_INT, OP_BRK, OP_PHP, OP_PLP, OP_RTI, OP_JSR, OP_RTS, OP_RST
  } seq_op_e;

  typedef enum logic [1:0] {VSEL_NMI, VSEL_RST, VSEL_IRQ} vec_sel_e;

  localparam int FLAG_I = 2;
  localparam int FLAG_B = 4;
  localparam int FLAG_R = 5;

  localparam logic [2:0] CMD_BRK = 3'd0;
  localparam logic [2:0] CMD_PHP = 3'd1;
  localparam logic [2:0] CMD_PLP = 3'd2;
  localparam logic [2:0] CMD_RTI = 3'd3;
  localparam logic [2:0] CMD_JSR = 3'd4;
  localparam logic [2:0] CMD_RTS = 3'd5;

  typedef struct packed {
    logic    valid;
    seq_op_e op;
  } cmd_dec_t;

  function automatic cmd_dec_t decode_cmd(logic [2:0] code);
    cmd_dec_t d;
    d.valid = 1'b1;
    d.op    = OP_INT;
    case (code)
      CMD_BRK: d.op = OP_BRK;
      CMD_PHP: d.op = OP_PHP;
      CMD_PLP: d.op = OP_PLP;
      CMD_RTI: d.op = OP_RTI;
      CMD_JSR: d.op = OP_JSR;
      CMD_RTS: d.op = OP_RTS;
      default: d.valid = 1'b0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/irq_stack_nmi_latch.sv
`timescale 1ns/1ps
module irq_stack_nmi_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nmi_ni,
  input  logic take_i,
  output logic pend_o
);
  logic nmi_q, pend_q, fall;

  assign fall   = nmi_q & ~nmi_ni;
  // same-cycle edge counts as pending
  assign pend_o = pend_q | fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nmi_q  <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      nmi_q  <= nmi_ni;
      pend_q <= pend_o & ~take_i;
    end
  end
endmodule

// File: rtl/irq_stack_arb.sv
`timescale 1ns/1ps
module irq_stack_arb
  import irq_stack_pkg::*;
(
  input  logic       idle_i,
  input  logic       reset_req_i,
  input  logic       boundary_i,
  input  logic       nmi_pend_i,
  input  logic       irq_ni,
  input  logic       i_flag_i,
  input  logic       cmd_valid_i,
  input  logic [2:0] cmd_i,
  output logic       go_o,
  output seq_op_e    op_o,
  output vec_sel_e   vec_o,
  output logic       nmi_take_o
);
  cmd_dec_t dec;
  logic     irq_ok;

  assign dec    = decode_cmd(cmd_i);
  assign irq_ok = ~irq_ni & ~i_flag_i;

  always_comb begin
    go_o       = 1'b0;
    op_o       = OP_INT;
    vec_o      = VSEL_IRQ;
    nmi_take_o = 1'b0;
    if (reset_req_i) begin
      go_o  = 1'b1;
      op_o  = OP_RST;
      vec_o = VSEL_RST;
    end else if (idle_i) begin
      if (boundary_i && nmi_pend_i) begin
        go_o       = 1'b1;
        vec_o      = VSEL_NMI;
        nmi_take_o = 1'b1;
      end else if (boundary_i && irq_ok) begin
        go_o = 1'b1;
      end else if (cmd_valid_i && dec.valid) begin
        go_o = 1'b1;
        op_o = dec.op;
      end
    end
  end
endmodule

// File: rtl/irq_stack_engine.sv
`timescale 1ns/1ps
module irq_stack_engine
  import irq_stack_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter logic [AW-DW-1:0] STACK_PAGE = 'h01,
  parameter logic [AW-1:0] VEC_NMI = 'hFFFA,
  parameter logic [AW-1:0] VEC_RST = 'hFFFC,
  parameter logic [AW-1:0] VEC_IRQ = 'hFFFE
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  seq_op_e       op_i,
  input  vec_sel_e      vec_i,
  input  logic [AW-1:0] jsr_target_i,
  input  logic          pc_set_i,
  input  logic [AW-1:0] pc_new_i,
  input  logic [DW-1:0] rdata_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic          we_o,
  output logic [AW-1:0] pc_o,
  output logic [DW-1:0] sp_o,
  output logic [DW-1:0] p_o,
  output logic          busy_o
);
  localparam logic [DW-1:0] ONE    = {{(DW-1){1'b0}}, 1'b1};
  localparam logic [DW-1:0] I_MASK = ONE << FLAG_I;
  localparam logic [DW-1:0] B_MASK = ONE << FLAG_B;
  localparam logic [DW-1:0] R_MASK = ONE << FLAG_R;
  localparam logic [AW-1:0] PC_ONE = {{(AW-1){1'b0}}, 1'b1};

  seq_state_e    state_q;
  seq_op_e       op_q;
  logic [AW-1:0] vaddr_q, push_w_q, tgt_q, pc_q;
  logic [DW-1:0] lo_q, sp_q, p_q, sp_inc, p_push;

  function automatic logic [AW-1:0] vec_of(vec_sel_e s);
    case (s)
      VSEL_NMI: return VEC_NMI;
      VSEL_RST: return VEC_RST;
      default:  return VEC_IRQ;
    endcase
  endfunction

  assign sp_inc = sp_q + ONE;
  assign p_push = (op_q == OP_INT) ? ((p_q & ~B_MASK) | R_MASK)
                                   : (p_q | B_MASK | R_MASK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      op_q     <= OP_INT;
      vaddr_q  <= '0;
      push_w_q <= '0;
      tgt_q    <= '0;
      lo_q     <= '0;
      pc_q     <= '0;
      sp_q     <= '1;
      p_q      <= R_MASK;
    end else if (go_i) begin
      op_q    <= op_i;
      vaddr_q <= vec_of(vec_i);
      tgt_q   <= jsr_target_i;
      case (op_i)
        OP_INT: begin push_w_q <= pc_q;          state_q <= ST_PUSH_HI; end
        OP_BRK: begin push_w_q <= pc_q + PC_ONE; state_q <= ST_PUSH_HI; end
        OP_JSR: begin push_w_q <= pc_q - PC_ONE; state_q <= ST_PUSH_HI; end
        OP_PHP: state_q <= ST_PUSH_P;
        OP_PLP, OP_RTI: state_q <= ST_PULL_P;
        OP_RTS: state_q <= ST_PULL_LO;
        default: begin
          sp_q    <= '1;
          p_q     <= R_MASK;
          state_q <= ST_VEC_LO;
        end
      endcase
    end else begin
      case (state_q)
        ST_IDLE: if (pc_set_i) pc_q <= pc_new_i;
        ST_PUSH_HI: begin
          sp_q    <= sp_q - ONE;
          state_q <= ST_PUSH_LO;
        end
        ST_PUSH_LO: begin
          sp_q <= sp_q - ONE;
          if (op_q == OP_JSR) begin
            pc_q    <= tgt_q;
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_PUSH_P;
          end
        end
        ST_PUSH_P: begin
          sp_q <= sp_q - ONE;
          if (op_q == OP_PHP) begin
            state_q <= ST_IDLE;
          end else begin
            p_q     <= p_q | I_MASK;
            state_q <= ST_VEC_LO;
          end
        end
        ST_VEC_LO: begin
          lo_q    <= rdata_i;
          state_q <= ST_VEC_HI;
        end
        ST_VEC_HI: begin
          pc_q    <= {rdata_i, lo_q};
          state_q <= ST_IDLE;
        end
        ST_PULL_P: begin
          sp_q    <= sp_inc;
          p_q     <= rdata_i | R_MASK;
          state_q <= (op_q == OP_PLP) ? ST_IDLE : ST_PULL_LO;
        end
        ST_PULL_LO: begin
          sp_q    <= sp_inc;
          lo_q    <= rdata_i;
          state_q <= ST_PULL_HI;
        end
        ST_PULL_HI: begin
          sp_q    <= sp_inc;
          pc_q    <= (op_q == OP_RTS) ? ({rdata_i, lo_q} + PC_ONE) : {rdata_i, lo_q};
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    we_o    = 1'b0;
    addr_o  = '0;
    wdata_o = '0;
    case (state_q)
      ST_PUSH_HI: begin we_o = 1'b1; addr_o = {STACK_PAGE, sp_q}; wdata_o = push_w_q[AW-1 -: DW]; end
      ST_PUSH_LO: begin we_o = 1'b1; addr_o = {STACK_PAGE, sp_q}; wdata_o = push_w_q[DW-1:0]; end
      ST_PUSH_P:  begin we_o = 1'b1; addr_o = {STACK_PAGE, sp_q}; wdata_o = p_push; end
      ST_VEC_LO:  addr_o = vaddr_q;
      ST_VEC_HI:  addr_o = vaddr_q + PC_ONE;
      ST_PULL_P, ST_PULL_LO, ST_PULL_HI: addr_o = {STACK_PAGE, sp_inc};
      default: ;
    endcase
  end

  assign pc_o   = pc_q;
  assign sp_o   = sp_q;
  assign p_o    = p_q;
  assign busy_o = (state_q != ST_IDLE);
endmodule

// File: rtl/irq_stack_seq.sv
`timescale 1ns/1ps
module irq_stack_seq
  import irq_stack_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter logic [AW-DW-1:0] STACK_PAGE = 'h01,
  parameter logic [AW-1:0] VEC_NMI = 'hFFFA,
  parameter logic [AW-1:0] VEC_RST = 'hFFFC,
  parameter logic [AW-1:0] VEC_IRQ = 'hFFFE
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reset_req_i,
  input  logic          boundary_i,
  input  logic          nmi_ni,
  input  logic          irq_ni,
  input  logic          cmd_valid_i,
  input  logic [2:0]    cmd_i,
  input  logic [AW-1:0] jsr_target_i,
  input  logic          pc_set_i,
  input  logic [AW-1:0] pc_new_i,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          mem_we_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [AW-1:0] pc_o,
  output logic [DW-1:0] sp_o,
  output logic [DW-1:0] status_o,
  output logic          busy_o
);
  logic     nmi_pend, nmi_take, go;
  seq_op_e  op;
  vec_sel_e vsel;

  irq_stack_nmi_latch u_nmi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .nmi_ni (nmi_ni),
    .take_i (nmi_take),
    .pend_o (nmi_pend)
  );

  irq_stack_arb u_arb (
    .idle_i      (~busy_o),
    .reset_req_i (reset_req_i),
    .boundary_i  (boundary_i),
    .nmi_pend_i  (nmi_pend),
    .irq_ni      (irq_ni),
    .i_flag_i    (status_o[FLAG_I]),
    .cmd_valid_i (cmd_valid_i),
    .cmd_i       (cmd_i),
    .go_o        (go),
    .op_o        (op),
    .vec_o       (vsel),
    .nmi_take_o  (nmi_take)
  );

  irq_stack_engine #(
    .AW(AW), .DW(DW), .STACK_PAGE(STACK_PAGE),
    .VEC_NMI(VEC_NMI), .VEC_RST(VEC_RST), .VEC_IRQ(VEC_IRQ)
  ) u_eng (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .go_i         (go),
    .op_i         (op),
    .vec_i        (vsel),
    .jsr_target_i (jsr_target_i),
    .pc_set_i     (pc_set_i),
    .pc_new_i     (pc_new_i),
    .rdata_i      (mem_rdata_i),
    .addr_o       (mem_addr_o),
    .wdata_o      (mem_wdata_o),
    .we_o         (mem_we_o),
    .pc_o         (pc_o),
    .sp_o         (sp_o),
    .p_o          (status_o),
    .busy_o       (busy_o)
  );
endmodule

// File: rtl/irq_stack_seq_chk.sv
`timescale 1ns/1ps
module irq_stack_seq_chk #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter logic [AW-DW-1:0] STACK_PAGE = 'h01
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          reset_req_i,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [DW-1:0] sp_o,
  input logic [DW-1:0] status_o,
  input logic          busy_o
);
  localparam logic [DW-1:0] RESET_P = {{(DW-6){1'b0}}, 6'h20};

  p_push_addr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_addr_o == {STACK_PAGE, sp_o}));

  p_push_dec_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && !reset_req_i) |=> (sp_o == $past(sp_o) - 1'b1));

  p_pull_inc_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !mem_we_o && mem_addr_o[AW-1:DW] == STACK_PAGE && !reset_req_i)
      |=> (sp_o == $past(sp_o) + 1'b1));

  p_reset_strobe_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_req_i |=> (sp_o == '1 && status_o == RESET_P && busy_o));

  p_reserved_bit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> status_o[5]);

  p_idle_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_we_o);
endmodule

bind irq_stack_seq irq_stack_seq_chk #(.AW(AW), .DW(DW), .STACK_PAGE(STACK_PAGE)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reset_req_i (reset_req_i),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .sp_o        (sp_o),
  .status_o    (status_o),
  .busy_o      (busy_o)
);

// File: tb/irq_stack_seq_tb.sv
`timescale 1ns/1ps
module irq_stack_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reset_req = 1'b0, boundary = 1'b0, nmi_n = 1'b1, irq_n = 1'b1;
  logic        cmd_valid = 1'b0, pc_set = 1'b0;
  logic [2:0]  cmd_code = 3'd0;
  logic [15:0] jsr_tgt = 16'h0, pc_new = 16'h0;
  logic [15:0] mem_addr, pc;
  logic [7:0]  mem_wdata, mem_rdata, sp, status;
  logic        mem_we, busy;

  logic [7:0] stk_mem [256];
  logic [7:0] vec_mem [8];

  always #2.5 clk = ~clk;

  assign mem_rdata = (mem_addr[15:8] == 8'h01) ? stk_mem[mem_addr[7:0]] :
                     (mem_addr >= 16'hFFFA)    ? vec_mem[mem_addr[2:0]] : 8'h00;

  irq_stack_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reset_req_i(reset_req), .boundary_i(boundary),
    .nmi_ni(nmi_n), .irq_ni(irq_n), .cmd_valid_i(cmd_valid), .cmd_i(cmd_code),
    .jsr_target_i(jsr_tgt), .pc_set_i(pc_set), .pc_new_i(pc_new),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_we_o(mem_we),
    .mem_rdata_i(mem_rdata), .pc_o(pc), .sp_o(sp), .status_o(status), .busy_o(busy)
  );

  // reference model
  typedef struct { bit we; int addr; int data; } bus_op_t;
  bus_op_t q[$];
  int m_pc, m_sp, m_p;
  logic [7:0] m_stk [256];
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  string cur_tag = "R11";

  task automatic chk(bit ok, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_tag, what, act, exp);
    end
  endtask

  function automatic void m_push(int d);
    q.push_back('{1'b1, 32'h100 + m_sp, d & 255});
    m_stk[m_sp] = 8'(d);
    m_sp = (m_sp - 1) & 255;
  endfunction

  function automatic int m_pull();
    m_sp = (m_sp + 1) & 255;
    q.push_back('{1'b0, 32'h100 + m_sp, 0});
    return int'(m_stk[m_sp]);
  endfunction

  function automatic void m_vec(int v);
    q.push_back('{1'b0, v, 0});
    q.push_back('{1'b0, v + 1, 0});
    m_pc = (int'(vec_mem[(v + 1) & 7]) << 8) | int'(vec_mem[v & 7]);
  endfunction

  function automatic void m_enter(int v, bit brk);
    int w;
    w = brk ? ((m_pc + 1) & 16'hFFFF) : m_pc;
    m_push(w >> 8);
    m_push(w & 255);
    m_push(brk ? (m_p | 'h30) : ((m_p & 'hEF) | 'h20));
    m_p = m_p | 4;
    m_vec(v);
  endfunction

  function automatic void m_rti();
    int lo, hi;
    m_p = m_pull() | 'h20;
    lo = m_pull();
    hi = m_pull();
    m_pc = (hi << 8) | lo;
  endfunction

  function automatic void m_reset();
    q.delete();
    m_sp = 255;
    m_p = 'h20;
    m_vec('hFFFC);
  endfunction

  task automatic preload(int v);
    stk_mem[(m_sp + 1) & 255] = 8'(v);
    m_stk[(m_sp + 1) & 255] = 8'(v);
  endtask

  task automatic check_cycle();
    bus_op_t e;
    if (q.size() > 0) begin
      e = q.pop_front();
      chk(busy === 1'b1, "busy", int'(busy), 1);
      chk(mem_we === e.we, "we", int'(mem_we), int'(e.we));
      chk(int'(mem_addr) == e.addr, "addr", int'(mem_addr), e.addr);
      if (e.we) chk(int'(mem_wdata) == e.data, "wdata", int'(mem_wdata), e.data);
    end else begin
      chk(busy === 1'b0, "idle busy", int'(busy), 0);
      chk(mem_we === 1'b0, "idle we", int'(mem_we), 0);
      chk(int'(pc) == m_pc, "pc", int'(pc), m_pc);
      chk(int'(sp) == m_sp, "sp", int'(sp), m_sp);
      chk(int'(status) == m_p, "status", int'(status), m_p);
    end
    if (mem_we === 1'b1) stk_mem[mem_addr[7:0]] = mem_wdata;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    check_cycle();
  endtask

  task automatic idle(int n);
    repeat (n) step();
  endtask

  task automatic issue(int code, int tgt);
    cmd_valid = 1'b1;
    cmd_code = 3'(code);
    jsr_tgt = 16'(tgt);
    step();
    cmd_valid = 1'b0;
  endtask

  task automatic do_rti();
    m_rti();
    issue(3, 0);
    idle(4);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin stk_mem[i] = 8'h00; m_stk[i] = 8'h00; end
    vec_mem[0] = 8'h00; vec_mem[1] = 8'h00;
    vec_mem[2] = 8'h00; vec_mem[3] = 8'h90;   // NMI  -> 9000
    vec_mem[4] = 8'h00; vec_mem[5] = 8'h80;   // RST  -> 8000
    vec_mem[6] = 8'h00; vec_mem[7] = 8'hA0;   // IRQ  -> A000
    m_pc = 0; m_sp = 255; m_p = 'h20;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    cur_tag = "R11"; check_cycle();
    idle(2);

    // R11: reset strobe loads reset vector
    cur_tag = "R11";
    m_reset(); reset_req = 1'b1; step(); reset_req = 1'b0; idle(3);

    // R13: PC overwrite while idle
    cur_tag = "R13";
    m_pc = 'h12FF; pc_set = 1'b1; pc_new = 16'h12FF; step(); pc_set = 1'b0; idle(1);

    // R9: call pushes PC-1
    cur_tag = "R9";
    m_push((m_pc - 1) >> 8); m_push((m_pc - 1) & 255); m_pc = 'h4000;
    issue(4, 'h4000); idle(3);

    // R10: return adds one
    cur_tag = "R10";
    begin int lo, hi; lo = m_pull(); hi = m_pull(); m_pc = (((hi << 8) | lo) + 1) & 16'hFFFF; end
    issue(5, 0); idle(3);

    // R6: push status
    cur_tag = "R6";
    m_push(m_p | 'h30); issue(1, 0); idle(2);

    // R7: pull status sets reserved bit (0xC4 -> 0xE4, I set)
    cur_tag = "R7";
    preload('hC4); m_p = m_pull() | 'h20; issue(2, 0); idle(2);

    // R2: IRQ masked while I=1
    cur_tag = "R2";
    irq_n = 1'b0; boundary = 1'b1; step(); boundary = 1'b0; idle(2);

    // R7: pull 0x01 -> 0x21, no boundary so IRQ not considered
    cur_tag = "R7";
    preload('h01); m_p = m_pull() | 'h20; issue(2, 0); idle(2);

    // R2 / R4: IRQ taken when I=0
    cur_tag = "R4";
    m_enter('hFFFE, 1'b0); boundary = 1'b1; step(); boundary = 1'b0; idle(6);
    irq_n = 1'b1;

    // R8: return from interrupt
    cur_tag = "R8";
    do_rti();

    // R5: break pushes PC+1 and B set
    cur_tag = "R5";
    m_enter('hFFFE, 1'b1); issue(0, 0); idle(6);
    cur_tag = "R8";
    do_rti();

    // R1: NMI and IRQ together, NMI wins
    cur_tag = "R1";
    m_enter('hFFFA, 1'b0);
    nmi_n = 1'b0; irq_n = 1'b0; boundary = 1'b1; step(); boundary = 1'b0; idle(6);
    cur_tag = "R8";
    do_rti();
    // R1: held-low NMI not re-taken; IRQ follows
    cur_tag = "R1";
    m_enter('hFFFE, 1'b0); boundary = 1'b1; step(); boundary = 1'b0; idle(6);
    irq_n = 1'b1; nmi_n = 1'b1;
    cur_tag = "R8";
    do_rti();

    // R1: NMI edge latched without boundary, wins over command later
    cur_tag = "R1";
    nmi_n = 1'b0; step(); idle(2);
    m_enter('hFFFA, 1'b0);
    boundary = 1'b1; cmd_valid = 1'b1; cmd_code = 3'd1; step();
    boundary = 1'b0; cmd_valid = 1'b0; idle(6);
    nmi_n = 1'b1;
    cur_tag = "R8";
    do_rti();

    // R12: invalid code ignored; command while busy ignored
    cur_tag = "R12";
    issue(7, 0); idle(1);
    issue(6, 0); idle(1);
    m_push(m_p | 'h30);
    issue(1, 0);
    cmd_valid = 1'b1; cmd_code = 3'd2; step(); cmd_valid = 1'b0; idle(2);

    // R11: reset strobe aborts a running return
    cur_tag = "R11";
    begin int lo, hi; lo = m_pull(); hi = m_pull(); m_pc = (((hi << 8) | lo) + 1) & 16'hFFFF; end
    issue(5, 0);
    m_reset(); reset_req = 1'b1; step(); reset_req = 1'b0; idle(3);

    // R3: stack pointer wraps both ways at page boundary
    cur_tag = "R3";
    preload('h0C); m_p = m_pull() | 'h20; issue(2, 0); idle(2);
    m_push(m_p | 'h30); issue(1, 0); idle(2);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule